// File: doc/BRIEF.md
# Multiplexed Address-Latch Host Bus Front End

This block is the host-facing entry stage of a byte-wide register file. The host presents a 12-bit address while it holds the address-latch strobe high, then drops that strobe. If chip select is low at that moment, the block captures the address. A later read strobe or write strobe carries out the data phase against that stored address. A static mode input enables this behaviour only when it is tied low.

Every host signal is asynchronous to the internal clock. Each one passes through a two-flop synchronizer, and the strobe edges are then found in the clock domain. Toward the register file, the block presents the held address and the write data. It also gives a single-cycle read pulse and a single-cycle write pulse. Read data from the register file is captured and kept on a byte-wide output for the host.

Top module: `hbi_front`

## Requirements
- R1: While reset is asserted, `reg_addr_o` is 0, `rdata_o` is 0, and `reg_rd_o` and `reg_wr_o` are low.
- R2: A falling edge on `ale_i` while `cs_n_i` is low and `mode_sel_i` is low loads `addr_i` into `reg_addr_o`. The new address is present 3 clock edges after the fall.
- R3: A falling edge on `ale_i` while `cs_n_i` is high leaves `reg_addr_o` unchanged.
- R4: `reg_addr_o` holds its value until the next qualifying falling edge of `ale_i`. A rising or held-high `ale_i` and changes on `addr_i` do not alter it.
- R5: A falling edge on `rd_n_i` with `cs_n_i` low raises `reg_rd_o` 3 edges later. On that same edge, `rdata_o` takes the value of `reg_rdata_i`, which is the register-file byte at `reg_addr_o`, and it keeps that value until the next read.
- R6: A rising edge on `wr_n_i` with `cs_n_i` low raises `reg_wr_o` 3 edges later. In that cycle `reg_wdata_o` equals the `wdata_i` that was held during the strobe, and `reg_addr_o` equals the latched address. No write pulse occurs while `wr_n_i` is low.
- R7: While `mode_sel_i` is high, no address is latched and neither pulse is raised.
- R8: Read and write strobes given while `cs_n_i` is high raise no pulse and leave `rdata_o` unchanged.
- R9: `reg_rd_o` and `reg_wr_o` each last exactly one clock cycle, however long the host holds its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Static mode select, low enables the latch-strobe bus |
| cs_n_i | input | 1 | Chip select, active low |
| ale_i | input | 1 | Address-latch strobe, address captured on its fall |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low, acts on its rise |
| addr_i | input | 12 | Host address bus |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Byte captured by the last accepted read |
| reg_addr_o | output | 12 | Latched address toward the register file |
| reg_rd_o | output | 1 | One-cycle read pulse |
| reg_wr_o | output | 1 | One-cycle write pulse |
| reg_wdata_o | output | 8 | Write data accompanying `reg_wr_o` |
| reg_rdata_i | input | 8 | Register-file byte at `reg_addr_o` |

## Verification
Every result is due exactly 3 clock edges after the host edge that causes it. Two of those edges are synchronizer stages, and the third is the output register. The pulses fall again on the fourth edge. The bench changes inputs on falling clock edges, waits three more falling edges, and then samples. One falling edge later it checks that each pulse has dropped. Held strobes are sampled again several cycles after that, to confirm no second pulse appears. Ignored stimuli are judged by comparing the latched address and the read byte with the values recorded before the stimulus.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef struct packed {
    logic cs_n;
    logic ale;
    logic rd_n;
    logic wr_n;
    logic mode;
  } hbi_ctl_t;

  localparam int CTL_W = $bits(hbi_ctl_t);
  localparam hbi_ctl_t CTL_IDLE = '{cs_n: 1'b1, ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1, mode: 1'b0};
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbi_edge.sv
module hbi_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= d;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign rise[b] = d[b] & ~prev_q[b];
    assign fall[b] = ~d[b] & prev_q[b];
  end
endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [ADDR_W-1:0] addr_s,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (latch_en) addr_d = addr_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/hbi_access.sv
module hbi_access #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata_s,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              rd_pulse,
  output logic              wr_pulse,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic              rd_pulse_d, wr_pulse_d;
  logic [DATA_W-1:0] wdata_d, rdata_d;

  always_comb begin
    rd_pulse_d = rd_stb;
    wr_pulse_d = wr_stb;
    wdata_d    = wdata_q;
    rdata_d    = rdata_q;
    if (wr_stb) wdata_d = wdata_s;
    if (rd_stb) rdata_d = rdata_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pulse <= 1'b0;
      wr_pulse <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      rd_pulse <= rd_pulse_d;
      wr_pulse <= wr_pulse_d;
      wdata_q  <= wdata_d;
      rdata_q  <= rdata_d;
    end
  end
endmodule

// File: rtl/hbi_front.sv
module hbi_front
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel_i,
  input  logic              cs_n_i,
  input  logic              ale_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int          EDGE_W   = 3;
  localparam logic [2:0]  EDGE_RST = {CTL_IDLE.ale, CTL_IDLE.rd_n, CTL_IDLE.wr_n};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  hbi_ctl_t          ctl_raw, ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdata_s;

  assign ctl_raw = '{cs_n: cs_n_i, ale: ale_i, rd_n: rd_n_i, wr_n: wr_n_i, mode: mode_sel_i};

  hbi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(ctl_raw), .q(ctl_s));

  hbi_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(addr_i), .q(addr_s));

  hbi_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_wdata_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(wdata_i), .q(wdata_s));

  logic [EDGE_W-1:0] stb_rise, stb_fall;

  hbi_edge #(.W(EDGE_W), .RST_VAL(EDGE_RST)) u_edge (
    .clk(clk), .rst_n(rst_sync_n),
    .d({ctl_s.ale, ctl_s.rd_n, ctl_s.wr_n}),
    .rise(stb_rise), .fall(stb_fall));

  logic intel_sel, cs_act, latch_stb, rd_stb, wr_stb;

  assign intel_sel = ~ctl_s.mode;
  assign cs_act    = ~ctl_s.cs_n & intel_sel;
  assign latch_stb = stb_fall[2] & cs_act;
  assign rd_stb    = stb_fall[1] & cs_act;
  assign wr_stb    = stb_rise[0] & cs_act;

  hbi_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_sync_n), .latch_en(latch_stb),
    .addr_s(addr_s), .addr_q(reg_addr_o));

  hbi_access #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata_s(wdata_s), .rdata_in(reg_rdata_i),
    .rd_pulse(reg_rd_o), .wr_pulse(reg_wr_o),
    .wdata_q(reg_wdata_o), .rdata_q(rdata_o));
endmodule

// File: rtl/hbi_front_chk.sv
module hbi_front_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              intel_sel,
  input logic              latch_stb,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              reg_rd_o,
  input logic              reg_wr_o,
  input logic [DATA_W-1:0] rdata_o
);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr_o) |-> $past(latch_stb));

  // R9
  rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> !reg_rd_o);

  // R9
  wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  // R6
  wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> $past(wr_stb));

  // R5
  rdata_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> reg_rd_o);

  // R7
  mode_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(intel_sel) |-> (!reg_rd_o && !reg_wr_o && $stable(reg_addr_o)));
endmodule

bind hbi_front hbi_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .intel_sel(intel_sel), .latch_stb(latch_stb),
  .wr_stb(wr_stb), .reg_addr_o(reg_addr_o), .reg_rd_o(reg_rd_o),
  .reg_wr_o(reg_wr_o), .rdata_o(rdata_o));

// File: tb/hbi_front_bench.sv
`timescale 1ns/1ps
module hbi_front_bench;
  logic        clk = 1'b0;
  logic        rst_n, mode_sel, cs_n, ale, rd_n, wr_n;
  logic [11:0] addr, reg_addr;
  logic [7:0]  wdata, rdata, reg_wdata, reg_rdata;
  logic        reg_rd, reg_wr;
  int          n_chk = 0, n_err = 0;
  logic [7:0]  last_rd;

  always #4 clk = ~clk;

  function automatic logic [7:0] rmodel(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]};
  endfunction

  assign reg_rdata = rmodel(reg_addr);

  hbi_front u_hbi_front (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel), .cs_n_i(cs_n), .ale_i(ale),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .reg_addr_o(reg_addr), .reg_rd_o(reg_rd), .reg_wr_o(reg_wr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata));

  localparam logic [19:0] VEC [4] = '{
    {12'hABC, 8'h5A}, {12'h000, 8'hFF}, {12'hFFF, 8'h00}, {12'h5A3, 8'hC3}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [11:0] a, input logic c);
    addr = a; cs_n = c; ale = 1'b1;
    step(4);
    ale = 1'b0;
    step(3);
  endtask

  task automatic do_read(input string tag, input logic exp_pulse, input logic [7:0] exp_data);
    rd_n = 1'b0;
    step(3);
    check(tag, reg_rd, exp_pulse);
    check(tag, rdata, exp_data);
    step(1);
    check("R9 read pulse end", reg_rd, 1'b0);
    step(4);
    check("R9 held read strobe", reg_rd, 1'b0);
    rd_n = 1'b1;
    step(3);
  endtask

  task automatic do_write(input string tag, input logic exp_pulse, input logic [7:0] d,
                          input logic [11:0] exp_addr);
    wdata = d; wr_n = 1'b0;
    step(4);
    check("R6 no pulse while low", reg_wr, 1'b0);
    wr_n = 1'b1;
    step(3);
    check(tag, reg_wr, exp_pulse);
    if (exp_pulse) begin
      check("R6 write data", reg_wdata, d);
      check("R6 write address", reg_addr, exp_addr);
    end
    step(1);
    check("R9 write pulse end", reg_wr, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 1'b0; cs_n = 1'b1; ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    addr = 12'h3C3; wdata = 8'hA5;
    step(2);
    check("R1 addr", reg_addr, 12'h000);
    check("R1 rdata", rdata, 8'h00);
    check("R1 rd", reg_rd, 1'b0);
    check("R1 wr", reg_wr, 1'b0);
    rst_n = 1'b1;
    step(4);

    for (int i = 0; i < 4; i++) begin
      latch(VEC[i][19:8], 1'b0);
      check("R2 latched address", reg_addr, VEC[i][19:8]);
      do_write("R6 write pulse", 1'b1, VEC[i][7:0], VEC[i][19:8]);
      do_read("R5 read pulse/data", 1'b1, rmodel(VEC[i][19:8]));
      last_rd = rmodel(VEC[i][19:8]);
    end

    // R3: fall with chip select high
    latch(12'h123, 1'b1);
    check("R3 ignored latch", reg_addr, 12'h5A3);

    // R8: strobes without chip select
    do_read("R8 read ignored", 1'b0, last_rd);
    do_write("R8 write ignored", 1'b0, 8'h77, 12'h5A3);

    // R4: ale high and address moving, no fall yet
    cs_n = 1'b0; ale = 1'b1; addr = 12'h246;
    step(5);
    check("R4 hold during ale high", reg_addr, 12'h5A3);
    addr = 12'h9E1;
    step(5);
    check("R4 hold with address change", reg_addr, 12'h5A3);
    ale = 1'b0;
    step(3);
    check("R4 next qualifying fall", reg_addr, 12'h9E1);
    addr = 12'h111;
    step(6);
    check("R4 hold after latch", reg_addr, 12'h9E1);
    do_read("R5 read after R4", 1'b1, rmodel(12'h9E1));
    last_rd = rmodel(12'h9E1);

    // R7: mode pin high blocks everything
    mode_sel = 1'b1;
    step(3);
    latch(12'h777, 1'b0);
    check("R7 no latch", reg_addr, 12'h9E1);
    do_read("R7 no read", 1'b0, last_rd);
    do_write("R7 no write", 1'b0, 8'h3E, 12'h9E1);
    mode_sel = 1'b0;
    step(3);
    latch(12'h777, 1'b0);
    check("R7 latch after mode low", reg_addr, 12'h777);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule